// File: doc/BRIEF.md
# Two-Channel PWM Output Qualifier with Shadowed Software Override

This block forms the final output levels of a two-channel pulse-width modulator. A separate time base supplies a tick enable and four event strobes: counter at zero, counter at period, counter matching compare A while counting up, and counter matching compare B while counting up. Each channel has its own action word. For every event, a 2-bit field in that word says whether the output is held, driven low, driven high or inverted. Normal and inverted polarity are not fixed in hardware. Software sets them by its choice of action codes. For example, on channel A, zero and period drive high and compare A drives low for normal polarity, and the opposite levels give inverted polarity.

Software can also hold either output at a fixed level through a continuous override word. Writes to this word land in a shadow copy. A reload-mode field in the same write decides when the shadow copy moves into the active copy: at the zero event, at the period event, at either of them, or on the very next tick. This lets software disable a channel cleanly on a cycle boundary, or at once.

Top module: `pwm_action_qualifier`

## Requirements
- R1: After reset, both outputs are low, every action field holds code 0 (no change), and no override is active, so events alone leave both outputs low.
- R2: The outputs, the active override and the reload itself change only in a cycle where `tick` is high. Event strobes in cycles without `tick` have no effect.
- R3: An action word has four 2-bit fields: zero event at bits [1:0], period event at [3:2], compare-A-up at [5:4] and compare-B-up at [9:8]. The codes are 0 hold, 1 low, 2 high and 3 invert. Bits [7:6] and [11:10] are ignored.
- R4: When events coincide on one tick, the output follows the highest-priority asserted event whose code is non-zero. The order is compare B, then compare A, then period, then zero. Asserted events with code 0 do not mask lower ones.
- R5: Override bits [1:0] act on channel A and bits [3:2] act on channel B. Code 1 forces low and code 2 forces high, and either one takes precedence over every event action. Codes 0 and 3 leave the event actions in control.
- R6: A write to the override word always updates the shadow copy and the reload mode (bits [7:6]) at that clock edge. A tick in the same cycle as the write still uses the previous shadow value and mode.
- R7: Reload mode 0 copies shadow to active on a tick with the zero event, mode 1 does so on a tick with the period event, and mode 2 does so on a tick with either. The override value just loaded already governs the output on that tick.
- R8: In reload mode 3 the shadow copy becomes active on every tick, so a newly written override controls the output from the first tick after the write.
- R9: Action word writes take effect at once without a shadow copy. The first tick after the write uses the new codes, including a change between normal and inverted polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base tick enable |
| ev_zero | input | 1 | Counter-at-zero event strobe |
| ev_period | input | 1 | Counter-at-period event strobe |
| ev_cmpa_up | input | 1 | Compare A match while counting up |
| ev_cmpb_up | input | 1 | Compare B match while counting up |
| act_a_we | input | 1 | Write strobe for the channel A action word |
| act_a_wdata | input | 12 | Channel A action word |
| act_b_we | input | 1 | Write strobe for the channel B action word |
| act_b_wdata | input | 12 | Channel B action word |
| ovr_we | input | 1 | Write strobe for the override word |
| ovr_wdata | input | 8 | Override word: A at [1:0], B at [3:2], reload mode at [7:6] |
| out_a | output | 1 | Channel A output level |
| out_b | output | 1 | Channel B output level |

## Verification
A stale or wrong active override shows up at the outputs on the first tick where the override would matter. The output then sits at a forced level while the event actions would move it, or moves while it should be held. A shadow copy that reloads at the wrong event shows up as a one-period shift in when a channel goes quiet. This matters most in zero-only and period-only modes, where the counter sequence makes the two events distinct ticks. The priority logic is exposed only when events coincide, so the stimulus uses compare values equal to zero and equal to the period, together with random strobe mixes. Every internal fault therefore reaches a port within one counter period.

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ev_zero,
  input  logic        ev_period,
  input  logic        ev_cmpa_up,
  input  logic        ev_cmpb_up,
  input  logic        act_a_we,
  input  logic [11:0] act_a_wdata,
  input  logic        act_b_we,
  input  logic [11:0] act_b_wdata,
  input  logic        ovr_we,
  input  logic [7:0]  ovr_wdata,
  output logic        out_a,
  output logic        out_b
);

  logic [9:0] act_a, act_b;
  logic [3:0] ovr_shd, ovr_act;
  logic [1:0] rld_mode;
  logic       reload;
  logic [3:0] ovr_use;

  always_comb begin
    case (rld_mode)
      2'd0:    reload = tick && ev_zero;
      2'd1:    reload = tick && ev_period;
      2'd2:    reload = tick && (ev_zero || ev_period);
      default: reload = tick;
    endcase
  end

  assign ovr_use = reload ? ovr_shd : ovr_act;

  function automatic logic next_level(input logic cur, input logic [9:0] act,
                                      input logic [1:0] ovr);
    logic [1:0] code;
    code = 2'd0;
    if (ev_zero    && act[1:0] != 2'd0) code = act[1:0];
    if (ev_period  && act[3:2] != 2'd0) code = act[3:2];
    if (ev_cmpa_up && act[5:4] != 2'd0) code = act[5:4];
    if (ev_cmpb_up && act[9:8] != 2'd0) code = act[9:8];
    if (ovr == 2'd1) return 1'b0;
    if (ovr == 2'd2) return 1'b1;
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
    end else begin
      if (act_a_we) act_a <= {act_a_wdata[9:8], act_a_wdata[5:0]} == 8'd0 ? 10'd0
                             : {act_a_wdata[9:8], 2'b00, act_a_wdata[5:0]};
      if (act_b_we) act_b <= {act_b_wdata[9:8], 2'b00, act_b_wdata[5:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_shd  <= '0;
      rld_mode <= '0;
    end else if (ovr_we) begin
      ovr_shd  <= ovr_wdata[3:0];
      rld_mode <= ovr_wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_act <= '0;
    else if (reload) ovr_act <= ovr_shd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else if (tick) begin
      out_a <= next_level(out_a, act_a, ovr_use[1:0]);
      out_b <= next_level(out_b, act_b, ovr_use[3:2]);
    end
  end

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_a) && $stable(out_b));

  assert_active_ovr_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ovr_act));

  assert_shadow_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_we |=> $stable(ovr_shd) && $stable(rld_mode));

  assert_immediate_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && rld_mode == 2'd3 && ovr_shd[1:0] == 2'd2 |=> out_a);

  assert_immediate_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && rld_mode == 2'd3 && ovr_shd[3:2] == 2'd1 |=> !out_b);

  assert_zero_mode_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ev_zero && rld_mode == 2'd0 |=> ovr_act == $past(ovr_shd));

endmodule

// File: tb/tb_pwm_action_qualifier.sv
`timescale 1ns/1ps
module tb_pwm_action_qualifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, ez = 0, ep = 0, eca = 0, ecb = 0;
  logic awe = 0, bwe = 0, fwe = 0;
  logic [11:0] awd = '0, bwd = '0;
  logic [7:0] fwd = '0;
  logic out_a, out_b;

  always #2 clk = ~clk;

  pwm_action_qualifier dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ev_zero(ez), .ev_period(ep), .ev_cmpa_up(eca), .ev_cmpb_up(ecb),
    .act_a_we(awe), .act_a_wdata(awd), .act_b_we(bwe), .act_b_wdata(bwd),
    .ovr_we(fwe), .ovr_wdata(fwd), .out_a(out_a), .out_b(out_b));

  int vectors = 0, errors = 0, cnt = 0;
  bit done = 0;
  string req = "R1";

  bit m_a, m_b;
  bit [11:0] m_acta, m_actb;
  bit [3:0] m_shd, m_act;
  bit [1:0] m_mode;

  function automatic bit ref_level(bit cur, bit [11:0] w, bit [1:0] f);
    int code = 0;
    int zc = w[1:0], pc = w[3:2], ac = w[5:4], bc = w[9:8];
    if (f == 1) return 0;
    if (f == 2) return 1;
    if (ecb && bc != 0) code = bc;
    else if (eca && ac != 0) code = ac;
    else if (ep && pc != 0) code = pc;
    else if (ez && zc != 0) code = zc;
    if (code == 1) return 0;
    if (code == 2) return 1;
    if (code == 3) return !cur;
    return cur;
  endfunction

  task automatic model_step();
    bit rl;
    bit [3:0] use_f;
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_acta = 0; m_actb = 0; m_shd = 0; m_act = 0; m_mode = 0;
      return;
    end
    if (tick) begin
      rl = (m_mode == 3) || (m_mode == 0 && ez) || (m_mode == 1 && ep) ||
           (m_mode == 2 && (ez || ep));
      use_f = rl ? m_shd : m_act;
      m_a = ref_level(m_a, m_acta, use_f[1:0]);
      m_b = ref_level(m_b, m_actb, use_f[3:2]);
      if (rl) m_act = m_shd;
    end
    if (awe) m_acta = awd;
    if (bwe) m_actb = bwd;
    if (fwe) begin m_shd = fwd[3:0]; m_mode = fwd[7:6]; end
  endtask

  task automatic apply();
    model_step();
    @(negedge clk);
    vectors++;
    if (out_a !== m_a) begin
      errors++;
      $display("FAIL %s out_a=%b expected=%b t=%0t", req, out_a, m_a, $time);
    end
    if (out_b !== m_b) begin
      errors++;
      $display("FAIL %s out_b=%b expected=%b t=%0t", req, out_b, m_b, $time);
    end
    awe = 0; bwe = 0; fwe = 0;
  endtask

  // counter-driven event pattern; tick every 'gap' cycles, random strobes between ticks
  task automatic run(int prd, int ca, int cb, int cycles, int gap);
    for (int i = 0; i < cycles; i++) begin
      tick = (i % gap) == 0;
      if (tick) begin
        ez = (cnt == 0); ep = (cnt == prd); eca = (cnt == ca); ecb = (cnt == cb);
      end else begin
        ez = $urandom % 2; ep = $urandom % 2; eca = $urandom % 2; ecb = $urandom % 2;
      end
      apply();
      if (tick) cnt = (cnt >= prd) ? 0 : cnt + 1;
    end
  endtask

  task automatic wr_force(bit [7:0] w);
    fwe = 1; fwd = w;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    req = "R1";
    rst_n = 0;
    repeat (3) apply();
    rst_n = 1;
    run(7, 3, 5, 20, 1);

    req = "R3";
    awe = 1; awd = 12'h0CA | 12'h010 | 12'h00A; // A normal: zero/period high, cmpA low, junk in [7:6]
    bwe = 1; bwd = 12'hC05 | 12'h200;           // B inverted: zero/period low, cmpB high, junk in [11:10]
    run(9, 3, 6, 40, 1);

    req = "R2";
    run(9, 3, 6, 60, 3);

    req = "R9";
    awe = 1; awd = 12'h025;  // A inverted
    bwe = 1; bwd = 12'h10A;  // B normal
    run(9, 4, 7, 30, 1);

    req = "R4";
    awe = 1; awd = 12'h31B;
    bwe = 1; bwd = 12'h2C6;
    run(5, 0, 5, 30, 1);
    for (int k = 0; k < 300; k++) begin
      tick = 1; ez = $urandom % 2; ep = $urandom % 2; eca = $urandom % 2; ecb = $urandom % 2;
      if (k % 17 == 0) begin awe = 1; awd = $urandom; bwe = 1; bwd = $urandom; end
      apply();
    end

    req = "R7";
    awe = 1; awd = 12'h01A; bwe = 1; bwd = 12'h10A;
    cnt = 0;
    wr_force(8'h09);   // mode 0: A low, B high
    run(8, 3, 5, 30, 1);
    wr_force(8'h40);   // mode 1: release
    run(8, 3, 5, 30, 1);
    wr_force(8'h86);   // mode 2: A high, B low
    run(8, 3, 5, 25, 2);
    wr_force(8'h8F);   // mode 2, code 3 = no force on both
    run(8, 3, 5, 25, 1);

    req = "R5";
    wr_force(8'hC6);
    run(6, 2, 4, 20, 1);
    wr_force(8'hC9);
    run(6, 2, 4, 20, 1);
    wr_force(8'hC0);
    run(6, 2, 4, 20, 1);

    req = "R6";
    tick = 1; ez = 0; ep = 0; eca = 0; ecb = 0;
    wr_force(8'hC5);   // write with tick in same cycle: old shadow used
    apply();
    apply();
    wr_force(8'h0A);   // mode 0 written; shadow waits for zero event
    run(6, 2, 4, 30, 1);

    req = "R8";
    for (int k = 0; k < 200; k++) begin
      tick = ($urandom % 3) != 0;
      ez = $urandom % 2; ep = $urandom % 2; eca = $urandom % 2; ecb = $urandom % 2;
      if (k % 7 == 0) wr_force({2'b11, 2'b00, 4'($urandom)});
      if (k % 23 == 0) wr_force(8'($urandom));
      apply();
    end

    req = "R1";
    rst_n = 0;
    apply();
    rst_n = 1;
    run(5, 1, 3, 20, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule